// File: doc/BRIEF.md
# I2C Burst Read Receiver

This block is the receive engine of an I2C master. It starts once an address phase has already claimed the bus. A single start strobe, together with a byte count, makes it read that many bytes from the addressed slave. Software does not step in between bytes.

The block generates every SCL pulse itself and samples SDA most significant bit first. It answers each byte on the ninth clock. It sends ACK while more bytes remain and NAK on the final byte. After the NAK it places a STOP condition on the bus, so the slave releases SDA.

Received bytes leave on a valid/ready port. When the consumer is slow, the block parks SCL low, which halts the slave until the byte is taken. A slave that stretches the clock is honoured: after releasing SCL, the block waits until the line really reads high before it times the high phase. The SCL rate can be one of three standard speeds, and the divider is computed from the system clock parameter. Both bus lines are open drain. The block only ever pulls a line low or releases it.

Top module: `i2c_burst_rx`

## Requirements
- R1: Out of reset and whenever no burst is running, the block releases both bus lines, and `busy`, `rx_valid` and `done` are low.
- R2: `rate_sel` sets the SCL speed: 0 gives 100 kHz, 1 gives 400 kHz, 2 gives 1 MHz, and 3 falls back to 100 kHz. The half period is CLK_HZ / (2 × rate) system clocks, rounded down. Each SCL high time inside a burst lasts that half period plus three clocks. The three clocks are the default two-stage input synchroniser plus one decision cycle.
- R3: The first data bit sampled in a byte lands in `rx_data[7]` and the eighth in `rx_data[0]`.
- R4: `burst_len` is captured when a burst is accepted, and exactly that many bytes (1 to 2^CNT_W − 1) are handed out on the receive port.
- R5: For every byte except the last, the block pulls SDA low through the whole ninth clock pulse (ACK).
- R6: On the last byte, the block leaves SDA released during the ninth clock (NAK). It then holds SDA low while SCL goes low and then high again, and releases SDA while SCL is high (STOP).
- R7: While a slave holds SCL low, the block waits, and no data bit is lost or shifted.
- R8: When a byte is complete and `rx_ready` is low, `rx_valid` stays high with `rx_data` unchanged, and SCL stays low until the byte is accepted.
- R9: A start with `burst_len` = 0 is accepted but rejected as empty. `done` is high in the clock after the start, `busy` stays low, and SCL is never pulled low.
- R10: `done` is a single-clock pulse. It is raised one half period after the STOP edge on SDA, in the same clock that `busy` falls.
- R11: A start strobe while a burst is running has no effect. The running burst keeps its original byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-clock strobe that begins a burst when idle |
| burst_len | input | CNT_W | Number of bytes to read, sampled with `start` |
| rate_sel | input | 2 | SCL speed select (0: 100 kHz, 1: 400 kHz, 2: 1 MHz, 3: 100 kHz) |
| rx_data | output | 8 | Received byte, MSB first on the wire |
| rx_valid | output | 1 | `rx_data` holds a completed byte |
| rx_ready | input | 1 | Consumer accepts the byte when high together with `rx_valid` |
| done | output | 1 | One-clock pulse at the end of a burst |
| busy | output | 1 | A burst occupies the bus |
| scl_drive_low | output | 1 | Pull SCL low (open drain) |
| scl_in | input | 1 | Sensed SCL level |
| sda_drive_low | output | 1 | Pull SDA low (open drain) |
| sda_in | input | 1 | Sensed SDA level |

## Verification
An empty start must show `done` exactly one clock after the accepting edge. Every SCL high pulse must last the half period plus three clocks. `done` must follow the SDA STOP rise by exactly one half period. Byte acceptance happens on the edge after a sample where `rx_valid` and `rx_ready` are both high, so that is where the byte is compared. The bench drives `rx_ready` and samples every output on the falling clock edge. Its reference model updates the ready level before it judges a handshake, which keeps each comparison aligned with the rising edge that acts on it. Stall and hold properties are compared on every clock against the previous sample.

// File: rtl/i2cbr_pkg.sv
package i2cbr_pkg;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ACK_SLOT = BYTE_W;

  typedef enum logic [3:0] {
    RX_IDLE,
    RX_LOW,
    RX_RISE,
    RX_HIGH,
    RX_HAND,
    RX_PLOW,
    RX_PRISE,
    RX_PHIGH,
    RX_PFREE,
    RX_DONE
  } rx_state_e;

  // SCL frequency in Hz for a rate select code
  function automatic int unsigned rate_hz(input logic [1:0] sel);
    case (sel)
      2'd1:    return 400_000;
      2'd2:    return 1_000_000;
      default: return 100_000;
    endcase
  endfunction

  // system clocks per SCL half period, rounded down
  function automatic int unsigned half_period(input int unsigned clk_hz,
                                              input logic [1:0]  sel);
    return clk_hz / (2 * rate_hz(sel));
  endfunction

endpackage

// File: rtl/i2cbr_sync.sv
module i2cbr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '1;
    else        q <= {q[STAGES-2:0], din};
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/i2cbr_timer.sv
module i2cbr_timer #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= (len == '0) ? '0 : len - 1'b1;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/i2cbr_shift.sv
module i2cbr_shift
  import i2cbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [BYTE_W-1:0] data
);
  logic [BYTE_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (shift_en) data_q <= {data_q[BYTE_W-2:0], bit_in};
  end

  assign data = data_q;
endmodule

// File: rtl/i2cbr_ctrl.sv
module i2cbr_ctrl
  import i2cbr_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned HP_W   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] burst_len,
  input  logic [1:0]       rate_sel,
  input  logic             scl_s,
  input  logic             tmr_exp,
  input  logic             rx_ready,
  output logic             tmr_load,
  output logic [HP_W-1:0]  hp_len,
  output logic             shift_en,
  output logic             scl_low,
  output logic             sda_low,
  output logic             rx_valid,
  output logic             done,
  output logic             busy,
  output logic             idle,
  output logic             ack_phase,
  output logic             last_byte,
  output logic             stop_free,
  output logic             zero_take
);
  localparam int unsigned BIT_W = $clog2(ACK_SLOT + 1);
  localparam logic [BIT_W-1:0] ACK_IDX  = BIT_W'(ACK_SLOT);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(ACK_SLOT - 1);

  rx_state_e        st_q, st_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [HP_W-1:0]  hp_q, hp_d;
  logic [HP_W-1:0]  hp_sel;

  assign hp_sel    = HP_W'(half_period(CLK_HZ, rate_sel));
  assign hp_len    = (st_q == RX_IDLE) ? hp_sel : hp_q;
  assign last_byte = (left_q == CNT_W'(1));

  always_comb begin
    st_d     = st_q;
    bit_d    = bit_q;
    left_d   = left_q;
    hp_d     = hp_q;
    tmr_load = 1'b0;
    shift_en = 1'b0;
    case (st_q)
      RX_IDLE: begin
        if (start) begin
          if (burst_len == '0) begin
            st_d = RX_DONE;
          end else begin
            st_d     = RX_LOW;
            tmr_load = 1'b1;
            bit_d    = '0;
            left_d   = burst_len;
            hp_d     = hp_sel;
          end
        end
      end
      RX_LOW: if (tmr_exp) st_d = RX_RISE;
      RX_RISE: begin
        if (scl_s) begin
          st_d     = RX_HIGH;
          tmr_load = 1'b1;
        end
      end
      RX_HIGH: begin
        if (tmr_exp) begin
          if (bit_q == ACK_IDX) begin
            tmr_load = 1'b1;
            if (last_byte) begin
              st_d = RX_PLOW;
            end else begin
              st_d   = RX_LOW;
              bit_d  = '0;
              left_d = left_q - 1'b1;
            end
          end else begin
            shift_en = 1'b1;
            if (bit_q == LAST_BIT) begin
              st_d  = RX_HAND;
              bit_d = ACK_IDX;
            end else begin
              st_d     = RX_LOW;
              tmr_load = 1'b1;
              bit_d    = bit_q + 1'b1;
            end
          end
        end
      end
      RX_HAND: begin
        if (rx_ready) begin
          st_d     = RX_LOW;
          tmr_load = 1'b1;
        end
      end
      RX_PLOW: if (tmr_exp) st_d = RX_PRISE;
      RX_PRISE: begin
        if (scl_s) begin
          st_d     = RX_PHIGH;
          tmr_load = 1'b1;
        end
      end
      RX_PHIGH: begin
        if (tmr_exp) begin
          st_d     = RX_PFREE;
          tmr_load = 1'b1;
        end
      end
      RX_PFREE: if (tmr_exp) st_d = RX_DONE;
      RX_DONE:  st_d = RX_IDLE;
      default:  st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      bit_q  <= '0;
      left_q <= '0;
      hp_q   <= '0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      left_q <= left_d;
      hp_q   <= hp_d;
    end
  end

  // bus line decode
  logic in_bit;
  assign in_bit    = (st_q == RX_LOW) || (st_q == RX_RISE) || (st_q == RX_HIGH);
  assign ack_phase = in_bit && (bit_q == ACK_IDX);
  assign scl_low   = (st_q == RX_LOW) || (st_q == RX_HAND) || (st_q == RX_PLOW);
  assign sda_low   = (ack_phase && !last_byte) || (st_q == RX_PLOW) ||
                     (st_q == RX_PRISE) || (st_q == RX_PHIGH);

  assign rx_valid  = (st_q == RX_HAND);
  assign done      = (st_q == RX_DONE);
  assign idle      = (st_q == RX_IDLE);
  assign busy      = !idle && !done;
  assign stop_free = (st_q == RX_PFREE);
  assign zero_take = idle && start && (burst_len == '0);
endmodule

// File: rtl/i2c_burst_rx.sv
module i2c_burst_rx
  import i2cbr_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] burst_len,
  input  logic [1:0]       rate_sel,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             done,
  output logic             busy,
  output logic             scl_drive_low,
  input  logic             scl_in,
  output logic             sda_drive_low,
  input  logic             sda_in
);
  localparam int unsigned HP_W = $clog2(CLK_HZ / 200_000 + 1);

  logic            scl_s, sda_s;
  logic            tmr_load, tmr_exp, shift_en;
  logic [HP_W-1:0] hp_len;

  // named events for the checker
  logic idle_w, ack_phase_w, last_w, stop_free_w, zero_take_w;

  i2cbr_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .din(scl_in), .dout(scl_s));

  i2cbr_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .din(sda_in), .dout(sda_s));

  i2cbr_timer #(.W(HP_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(hp_len), .expired(tmr_exp));

  i2cbr_shift u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bit_in(sda_s), .data(rx_data));

  i2cbr_ctrl #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W), .HP_W(HP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .burst_len(burst_len),
    .rate_sel(rate_sel), .scl_s(scl_s), .tmr_exp(tmr_exp), .rx_ready(rx_ready),
    .tmr_load(tmr_load), .hp_len(hp_len), .shift_en(shift_en),
    .scl_low(scl_drive_low), .sda_low(sda_drive_low), .rx_valid(rx_valid),
    .done(done), .busy(busy), .idle(idle_w), .ack_phase(ack_phase_w),
    .last_byte(last_w), .stop_free(stop_free_w), .zero_take(zero_take_w));
endmodule

// File: rtl/i2cbr_chk.sv
module i2cbr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       rx_ready,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       done,
  input logic       busy,
  input logic       scl_drive_low,
  input logic       sda_drive_low,
  input logic       idle_w,
  input logic       ack_phase_w,
  input logic       last_w,
  input logic       stop_free_w,
  input logic       zero_take_w
);
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_w |-> (!scl_drive_low && !sda_drive_low && !rx_valid && !busy));

  // R5
  ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_phase_w && !last_w) |-> sda_drive_low);

  // R6
  nak_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_phase_w && last_w) |-> !sda_drive_low);

  // R8
  hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R8
  stall_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> scl_drive_low);

  // R9
  zero_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_take_w |=> (done && !busy && !scl_drive_low));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(stop_free_w) || $past(zero_take_w)));

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind i2c_burst_rx i2cbr_chk u_chk (.*);

// File: tb/i2c_burst_rx_tb.sv
module i2c_burst_rx_tb;
  localparam int unsigned CLK_HZ = 8_000_000;
  localparam int unsigned CNT_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             start = 1'b0;
  logic [CNT_W-1:0] burst_len = '0;
  logic [1:0]       rate_sel = 2'd0;
  logic             rx_ready = 1'b1;
  wire  [7:0]       rx_data;
  wire              rx_valid, done, busy, scl_drive_low, sda_drive_low;
  logic             sl_sda_low = 1'b0;
  logic             sl_stretch = 1'b0;
  wire              scl_bus = !(scl_drive_low || sl_stretch);
  wire              sda_bus = !(sda_drive_low || sl_sda_low);

  i2c_burst_rx #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .burst_len(burst_len),
    .rate_sel(rate_sel), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .done(done), .busy(busy),
    .scl_drive_low(scl_drive_low), .scl_in(scl_bus),
    .sda_drive_low(sda_drive_low), .sda_in(sda_bus));

  int checks = 0;
  int bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_hp(input logic [1:0] s);
    case (s)
      2'd1:    return CLK_HZ / 800_000;
      2'd2:    return CLK_HZ / 2_000_000;
      default: return CLK_HZ / 200_000;
    endcase
  endfunction

  function automatic logic [7:0] pattern_byte(input int sd, input int i);
    return 8'((sd * 29 + i * 83) ^ (i * 16 + 1));
  endfunction

  // slave model
  bit         armed = 0;
  int         bi = 0, bidx = 0, seed = 0, str_len = 0, str_cnt = 0;
  bit         prev_scl = 1;
  bit         ack_q[$];
  logic [7:0] sl_byte;

  always @(posedge clk) begin
    if (armed && !prev_scl && scl_bus) begin
      if (bi < 8) bi++;
      else begin
        ack_q.push_back(sda_bus);
        bi = 0;
        bidx++;
        if (sda_bus) armed = 0;
      end
    end
    if (armed && prev_scl && !scl_bus && str_len > 0) begin
      sl_stretch <= 1'b1;
      str_cnt = str_len;
    end else if (str_cnt > 0) begin
      str_cnt--;
      if (str_cnt == 0) sl_stretch <= 1'b0;
    end
    if (!scl_bus) begin
      sl_byte = pattern_byte(seed, bidx);
      sl_sda_low <= (armed && bi < 8) ? !sl_byte[7 - bi] : 1'b0;
    end
    prev_scl = scl_bus;
  end

  // reference model, compared every clock
  int         cyc = 0, hi_run = 0, lo_run = 0, max_lo = 0, cur_hp = 40;
  int         stop_cyc = -1, done_cyc = -1, done_cnt = 0, got = 0, scl_falls = 0;
  int         rdy_mode = 0;
  bit         prev_scl_n = 1, prev_sda_n = 1, prev_stall = 0;
  logic [7:0] prev_data;
  logic [7:0] exp_q[$];
  logic [7:0] exp_b;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      case (rdy_mode)
        0:       rx_ready = 1'b1;
        1:       rx_ready = (cyc % 7) < 3;
        default: rx_ready = ((cyc / 60) % 2) == 1;
      endcase
      if (!busy) begin
        hi_run = 0;
        lo_run = 0;
      end else if (scl_bus) begin
        hi_run++;
        lo_run = 0;
      end else begin
        if (hi_run > 0) check(hi_run == cur_hp + 3, "R2", "SCL high time", hi_run, cur_hp + 3);
        hi_run = 0;
        lo_run++;
        if (lo_run > max_lo) max_lo = lo_run;
      end
      if (prev_scl_n && !scl_bus) scl_falls++;
      if (!prev_sda_n && sda_bus && scl_bus) stop_cyc = cyc;
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
      end
      if (rx_valid) check(!scl_bus, "R8", "SCL low while byte waits", int'(scl_bus), 0);
      if (prev_stall) begin
        check(rx_valid, "R8", "valid held", int'(rx_valid), 1);
        check(rx_data == prev_data, "R8", "data held", int'(rx_data), int'(prev_data));
      end
      if (rx_valid && rx_ready) begin
        if (exp_q.size() == 0) check(0, "R4", "byte beyond count", got + 1, got);
        else begin
          exp_b = exp_q.pop_front();
          check(rx_data == exp_b, "R3", "received byte", int'(rx_data), int'(exp_b));
        end
        got++;
      end
      prev_stall = rx_valid && !rx_ready;
      prev_data  = rx_data;
      prev_scl_n = scl_bus;
      prev_sda_n = sda_bus;
    end
  end

  task automatic run_burst(input int len, input logic [1:0] sel, input int str,
                           input int rmode, input int sd, input int restart_len);
    int t;
    @(negedge clk);
    seed = sd; str_len = str; rdy_mode = rmode; cur_hp = exp_hp(sel);
    armed = (len > 0); bi = 0; bidx = 0;
    ack_q.delete(); exp_q.delete();
    got = 0; done_cnt = 0; stop_cyc = -1; done_cyc = -1; scl_falls = 0; max_lo = 0;
    for (int i = 0; i < len; i++) exp_q.push_back(pattern_byte(sd, i));
    burst_len = CNT_W'(len); rate_sel = sel; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart_len > 0) begin
      repeat (30) @(negedge clk);
      burst_len = CNT_W'(restart_len); start = 1'b1;   // R11 stimulus
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (done_cnt == 0 && t < 30000) begin
      @(negedge clk);
      t++;
    end
    repeat (5) @(negedge clk);
    check(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
    check(got == len, restart_len > 0 ? "R11" : "R4", "bytes delivered", got, len);
    check(ack_q.size() == len, "R5", "answer slots", ack_q.size(), len);
    for (int i = 0; i < len && i < ack_q.size(); i++) begin
      if (i < len - 1) check(ack_q[i] == 1'b0, "R5", "ACK level", int'(ack_q[i]), 0);
      else             check(ack_q[i] == 1'b1, "R6", "NAK level", int'(ack_q[i]), 1);
    end
    check(stop_cyc > 0, "R6", "STOP seen", stop_cyc, 1);
    check(done_cyc - stop_cyc == cur_hp, "R10", "STOP to done", done_cyc - stop_cyc, cur_hp);
    check(scl_bus && sda_bus && !busy, "R1", "bus free after burst",
          int'({scl_bus, sda_bus, busy}), 6);
    if (str > 0) check(max_lo >= str, "R7", "stretched low time", max_lo, str);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!scl_drive_low && !sda_drive_low, "R1", "lines in reset",
          int'({scl_drive_low, sda_drive_low}), 0);
    check(!busy && !rx_valid && !done, "R1", "flags in reset",
          int'({busy, rx_valid, done}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!scl_drive_low && !sda_drive_low && !busy, "R1", "idle after reset",
          int'({scl_drive_low, sda_drive_low, busy}), 0);

    run_burst(3, 2'd2, 0, 0, 5, 0);     // 1 MHz, free flow
    run_burst(4, 2'd1, 25, 1, 11, 0);   // 400 kHz, stretching, choppy ready (R7)
    run_burst(2, 2'd0, 0, 2, 3, 0);     // 100 kHz, long stalls (R8)
    run_burst(1, 2'd3, 0, 0, 9, 0);     // code 3 falls back to 100 kHz, single byte
    run_burst(3, 2'd2, 0, 0, 17, 6);    // restart while busy ignored (R11)

    // R9 empty burst
    @(negedge clk);
    armed = 0; scl_falls = 0; done_cnt = 0;
    burst_len = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R9", "done after empty start", int'(done), 1);
    check(busy == 1'b0, "R9", "busy on empty start", int'(busy), 0);
    @(negedge clk);
    check(done == 1'b0, "R10", "done width", int'(done), 0);
    repeat (20) @(negedge clk);
    check(scl_falls == 0, "R9", "SCL activity on empty start", scl_falls, 0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule